// File: doc/BRIEF.md
# SDRAM Bank Command Timing Tracker

The tracker sits beside an SDRAM command bus and checks every command a controller issues against per-bank state and cycle timers. It decodes the active-low select, row-strobe, column-strobe and write-enable lines on each rising clock edge, together with a two-bit bank address and the A10 precharge-option bit. It then keeps one state machine per bank (idle, activating, active, precharging, auto-precharging) plus a small set of global timers. All timing limits are parameters counted in clock cycles.

A command that breaks a rule is reported by a one-cycle violation pulse in the cycle after it was sampled. The pulse comes with an error code, and the command is given no effect on any bank. A controller may also use the per-bank ready vectors, which say whether ACT, READ/WRITE or PRE would be accepted in the current cycle. The burst length is a live input, because the auto-precharge windows depend on it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With sel_ni high, the command is a deselect, whatever the other pins are. With sel_ni low and row/col/wen = 111 the command is NOP. Neither is ever flagged, and neither changes any bank. The other encodings, as {row,col,wen} with select low, are: ACT 011, READ 101, WRITE 100, PRE 010, REFA 001, MRS 000, TERM 110.
- R2: ACT to an idle bank opens it. The bank reports state 1 (activating) until T_RCD cycles after the ACT and state 2 (active) from then on. A READ or WRITE to that bank earlier than T_RCD cycles after its ACT gets code 1 (early).
- R3: An ACT issued fewer than T_RRD cycles after the previous accepted ACT, to any bank, gets code 1.
- R4: PRE with A10 low to an open bank closes it, provided at least T_RAS cycles have passed since its ACT; otherwise it gets code 1. The bank reports state 3 until T_RP cycles after the PRE and state 0 (idle) from then on. An ACT to it before then gets code 1. PRE to an idle or precharging bank is accepted and changes nothing.
- R5: PRE with A10 high ignores the bank address and closes every open bank at once, under the same T_RAS rule for each of them.
- R6: READ or WRITE with A10 high puts the bank in state 4 (auto-precharging). It returns to idle, and will accept ACT, BL+T_RP cycles after a READ and BL+T_WR-1+T_RP cycles after a WRITE. BL is 1, 2, 4 or 8 for bl_code_i 0 to 3.
- R7: While a bank is auto-precharging, READ, WRITE, PRE (single or all), ACT and TERM aimed at it get code 2 (wrong state). Commands to other banks are unaffected.
- R8: REFA or MRS while any bank is not idle gets code 3 (global command with a bank open).
- R9: Any command other than NOP or deselect gets code 1 if it comes within T_RFC cycles after an accepted REFA or within T_RSC cycles after an accepted MRS.
- R10: READ or WRITE with A10 high gets code 1 if its internal precharge would begin less than T_RAS cycles after the bank's ACT. That begin point is BL cycles after the READ, or BL+T_WR-1 cycles after the WRITE.
- R11: When bl_code_i[2] is 1 (full-page burst), READ or WRITE with A10 high to an active bank gets code 4 (illegal mode).
- R12: A flagged command changes no bank and no timer. viol_o and err_code_o are registered: they show the result of the command sampled at the previous edge, so violations appear as one-cycle pulses. The order of checks is: lockout, then bank state, then mode, then timing.
- R13: may_act_o, may_rw_o and may_pre_o each give, per bank, whether ACT, READ/WRITE without A10, or single PRE would be accepted in the current cycle. After reset every bank is idle, ACT and PRE are ready, and READ/WRITE is not.
- R14: READ, WRITE or TERM to a bank that is not in the required state, or ACT to an open bank, gets code 2. Specifically, READ or WRITE needs the bank open, and TERM is refused only for an auto-precharging bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Chip select, active low |
| row_ni | input | 1 | Row strobe, active low |
| col_ni | input | 1 | Column strobe, active low |
| wen_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Auto-precharge / precharge-all option |
| bl_code_i | input | 3 | Burst length code: 0..3 give 1,2,4,8; bit 2 set is full page |
| viol_o | output | 1 | Pulse: previous command violated a rule |
| err_code_o | output | 3 | 0 none, 1 early, 2 wrong state, 3 bank open for global, 4 illegal mode |
| bank_state_o | output | 12 | 3 bits per bank: 0 idle, 1 activating, 2 active, 3 precharging, 4 auto-precharging |
| may_act_o | output | 4 | Per bank: ACT would be accepted now |
| may_rw_o | output | 4 | Per bank: READ/WRITE would be accepted now |
| may_pre_o | output | 4 | Per bank: single PRE would be accepted now |

## Verification
The embedded properties take the command pins and the burst-length code to be known values, settled before each rising edge. They also take bl_code_i to be held steady across the edge where a command is sampled, since the auto-precharge window is latched there. The bench changes every input only on the falling edge, which keeps within these conditions. In its random phase it changes the burst-length code only between commands, so that the auto-precharge windows stay well defined. It leaves the protocol rules themselves free to be broken, so that the flagging paths are exercised.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_TERM
  } cmd_e;

  typedef enum logic [1:0] {PH_IDLE, PH_OPEN, PH_PRECH, PH_AUTOPRE} phase_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_EARLY = 3'd1, ERR_STATE = 3'd2, ERR_GLOBAL = 3'd3, ERR_MODE = 3'd4
  } err_e;

  localparam logic [2:0] ST_IDLE    = 3'd0;
  localparam logic [2:0] ST_ACTVG   = 3'd1;
  localparam logic [2:0] ST_ACTIVE  = 3'd2;
  localparam logic [2:0] ST_PRECH   = 3'd3;
  localparam logic [2:0] ST_AUTOPRE = 3'd4;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic sel_ni,
  input  logic row_ni,
  input  logic col_ni,
  input  logic wen_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (sel_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({row_ni, col_ni, wen_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_TERM;
      endcase
    end
  end
endmodule

// File: rtl/sdram_global_timer.sv
module sdram_global_timer #(
  parameter int T_RRD = 2,
  parameter int T_RFC = 8,
  parameter int T_RSC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_go_i,
  input  logic ref_go_i,
  input  logic mrs_go_i,
  output logic rrd_ok_o,
  output logic lock_o
);
  localparam int RRD_W  = $clog2(T_RRD + 1);
  localparam int LOCK_M = (T_RFC > T_RSC) ? T_RFC : T_RSC;
  localparam int LOCK_W = $clog2(LOCK_M + 1);

  logic [RRD_W-1:0]  rrd_q;
  logic [LOCK_W-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rrd_q <= '0;
    else if (act_go_i) rrd_q <= RRD_W'(T_RRD - 1);
    else if (rrd_q != '0) rrd_q <= rrd_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else if (ref_go_i) lock_q <= LOCK_W'(T_RFC - 1);
    else if (mrs_go_i) lock_q <= LOCK_W'(T_RSC - 1);
    else if (lock_q != '0) lock_q <= lock_q - 1'b1;
  end

  assign rrd_ok_o = (rrd_q == '0);
  assign lock_o   = (lock_q != '0);

  p_rrd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go_i |-> rrd_q == '0);
  p_lock_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_go_i || mrs_go_i || act_go_i) |-> lock_q == '0);
endmodule

// File: rtl/sdram_bank_ctl.sv
module sdram_bank_ctl
  import sdram_trk_pkg::*;
#(
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_WR   = 2,
  parameter int T_RAS  = 5,
  parameter int MAX_BL = 8,
  parameter int BL_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            act_i,
  input  logic            pre_i,
  input  logic            rda_i,
  input  logic            wra_i,
  input  logic [BL_W-1:0] bl_i,
  output phase_e          phase_o,
  output logic [2:0]      state_o,
  output logic            rcd_ok_o,
  output logic            ras_ok_o,
  output logic            rda_ras_ok_o,
  output logic            wra_ras_ok_o
);
  localparam int RP_MAX = MAX_BL + T_WR - 1 + T_RP;
  localparam int RP_W   = $clog2(RP_MAX + 1);
  localparam int RCD_W  = $clog2(T_RCD + 1);
  localparam int RAS_W  = $clog2(T_RAS + 1);

  phase_e           phase_q;
  logic [RP_W-1:0]  rp_q, rp_load;
  logic [RCD_W-1:0] rcd_q;
  logic [RAS_W-1:0] ras_q;

  // cycles until the bank may reopen, minus one
  always_comb begin
    if (pre_i)      rp_load = RP_W'(T_RP - 1);
    else if (rda_i) rp_load = RP_W'(int'(bl_i) + T_RP - 1);
    else            rp_load = RP_W'(int'(bl_i) + T_WR + T_RP - 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rp_q    <= '0;
    end else if (act_i) begin
      phase_q <= PH_OPEN;
    end else if (pre_i || rda_i || wra_i) begin
      rp_q <= rp_load;
      if (rp_load == '0) phase_q <= PH_IDLE;
      else               phase_q <= pre_i ? PH_PRECH : PH_AUTOPRE;
    end else if (phase_q == PH_PRECH || phase_q == PH_AUTOPRE) begin
      if (rp_q != '0) rp_q <= rp_q - 1'b1;
      if (rp_q <= RP_W'(1)) phase_q <= PH_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcd_q <= '0;
      ras_q <= '0;
    end else if (act_i) begin
      rcd_q <= RCD_W'(T_RCD - 1);
      ras_q <= RAS_W'(T_RAS - 1);
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_IDLE:  state_o = ST_IDLE;
      PH_OPEN:  state_o = (rcd_q != '0) ? ST_ACTVG : ST_ACTIVE;
      PH_PRECH: state_o = ST_PRECH;
      default:  state_o = ST_AUTOPRE;
    endcase
  end

  assign phase_o      = phase_q;
  assign rcd_ok_o     = (rcd_q == '0);
  assign ras_ok_o     = (ras_q == '0);
  assign rda_ras_ok_o = int'(ras_q) <= int'(bl_i);
  assign wra_ras_ok_o = int'(ras_q) <= int'(bl_i) + T_WR - 1;

  p_act_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> phase_q == PH_IDLE);
  p_ap_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_i || wra_i) |-> (phase_q == PH_OPEN && rcd_q == '0));
  p_pre_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (phase_q == PH_OPEN && ras_q == '0));
  p_ap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_AUTOPRE |=> (phase_q == PH_AUTOPRE || phase_q == PH_IDLE));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RRD = 2,
  parameter int T_WR  = 2,
  parameter int T_RAS = 5,
  parameter int T_RFC = 8,
  parameter int T_RSC = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_ni,
  input  logic                      row_ni,
  input  logic                      col_ni,
  input  logic                      wen_ni,
  input  logic [BA_W-1:0]           ba_i,
  input  logic                      a10_i,
  input  logic [2:0]                bl_code_i,
  output logic                      viol_o,
  output logic [2:0]                err_code_o,
  output logic [3*(1<<BA_W)-1:0]    bank_state_o,
  output logic [(1<<BA_W)-1:0]      may_act_o,
  output logic [(1<<BA_W)-1:0]      may_rw_o,
  output logic [(1<<BA_W)-1:0]      may_pre_o
);
  localparam int NB     = 1 << BA_W;
  localparam int MAX_BL = 8;
  localparam int BL_W   = $clog2(MAX_BL + 1);

  cmd_e            cmd;
  phase_e          phase [NB];
  logic [NB-1:0]   rcd_ok, ras_ok, rda_ok, wra_ok;
  logic [NB-1:0]   act_v, pre_v, rda_v, wra_v;
  logic            ref_go, mrs_go, rrd_ok, lock_w, full_page;
  logic [BL_W-1:0] bl_cnt;
  err_e            err;
  logic            viol_q;
  logic [2:0]      code_q;

  sdram_cmd_decode u_dec (
    .sel_ni(sel_ni), .row_ni(row_ni), .col_ni(col_ni), .wen_ni(wen_ni), .cmd_o(cmd)
  );

  assign full_page = bl_code_i[2];
  assign bl_cnt    = BL_W'(1) << bl_code_i[1:0];

  sdram_global_timer #(.T_RRD(T_RRD), .T_RFC(T_RFC), .T_RSC(T_RSC)) u_glb (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_go_i(|act_v), .ref_go_i(ref_go),
    .mrs_go_i(mrs_go), .rrd_ok_o(rrd_ok), .lock_o(lock_w)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_ctl #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RAS(T_RAS), .MAX_BL(MAX_BL), .BL_W(BL_W)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_v[b]), .pre_i(pre_v[b]),
      .rda_i(rda_v[b]), .wra_i(wra_v[b]), .bl_i(bl_cnt), .phase_o(phase[b]),
      .state_o(bank_state_o[3*b +: 3]), .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]),
      .rda_ras_ok_o(rda_ok[b]), .wra_ras_ok_o(wra_ok[b])
    );

    assign may_act_o[b] = (phase[b] == PH_IDLE) && rrd_ok && !lock_w;
    assign may_rw_o[b]  = (phase[b] == PH_OPEN) && rcd_ok[b] && !lock_w;
    assign may_pre_o[b] = ((phase[b] == PH_OPEN) ? ras_ok[b] : (phase[b] != PH_AUTOPRE))
                          && !lock_w;
  end

  // legality check; a flagged command raises no bank strobe
  always_comb begin
    logic any_busy, any_ap, any_early;
    logic [NB-1:0] open_m;
    err    = ERR_NONE;
    act_v  = '0;
    pre_v  = '0;
    rda_v  = '0;
    wra_v  = '0;
    ref_go = 1'b0;
    mrs_go = 1'b0;
    any_busy  = 1'b0;
    any_ap    = 1'b0;
    any_early = 1'b0;
    for (int b = 0; b < NB; b++) begin
      open_m[b] = (phase[b] == PH_OPEN);
      any_busy  = any_busy | (phase[b] != PH_IDLE);
      any_ap    = any_ap | (phase[b] == PH_AUTOPRE);
      any_early = any_early | (open_m[b] & ~ras_ok[b]);
    end
    if (lock_w && cmd != CMD_NOP && cmd != CMD_DESEL) err = ERR_EARLY;
    else begin
      unique case (cmd)
        CMD_ACT: begin
          if (phase[ba_i] == PH_PRECH)     err = ERR_EARLY;
          else if (phase[ba_i] != PH_IDLE) err = ERR_STATE;
          else if (!rrd_ok)                err = ERR_EARLY;
          else                             act_v[ba_i] = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (phase[ba_i] != PH_OPEN)   err = ERR_STATE;
          else if (a10_i && full_page)  err = ERR_MODE;
          else if (!rcd_ok[ba_i])       err = ERR_EARLY;
          else if (a10_i && !((cmd == CMD_RD) ? rda_ok[ba_i] : wra_ok[ba_i])) err = ERR_EARLY;
          else if (a10_i) begin
            if (cmd == CMD_RD) rda_v[ba_i] = 1'b1;
            else               wra_v[ba_i] = 1'b1;
          end
        end
        CMD_PRE: begin
          if (a10_i) begin
            if (any_ap)         err = ERR_STATE;
            else if (any_early) err = ERR_EARLY;
            else                pre_v = open_m;
          end else if (phase[ba_i] == PH_AUTOPRE) err = ERR_STATE;
          else if (open_m[ba_i]) begin
            if (!ras_ok[ba_i]) err = ERR_EARLY;
            else               pre_v[ba_i] = 1'b1;
          end
        end
        CMD_TERM: if (phase[ba_i] == PH_AUTOPRE) err = ERR_STATE;
        CMD_REF, CMD_MRS: begin
          if (any_busy)           err = ERR_GLOBAL;
          else if (cmd == CMD_REF) ref_go = 1'b1;
          else                     mrs_go = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      code_q <= 3'd0;
    end else begin
      viol_q <= (err != ERR_NONE);
      code_q <= err;
    end
  end

  assign viol_o     = viol_q;
  assign err_code_o = code_q;

  p_idle_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_NOP || cmd == CMD_DESEL) |=> !viol_o);
  p_lockout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_w && cmd != CMD_NOP && cmd != CMD_DESEL) |=> (viol_o && err_code_o == 3'd1));
  p_global_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_go || mrs_go) |=> bank_state_o == '0);
  p_code_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> err_code_o != 3'd0);
endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  localparam int TRCD = 2, TRP = 2, TRRD = 2, TWR = 2, TRAS = 5, TRFC = 8, TRSC = 2;
  localparam int K_DESEL = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4, K_PRE = 5,
                 K_REF = 6, K_MRS = 7, K_TERM = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sel_ni = 1'b1, row_ni = 1'b1, col_ni = 1'b1, wen_ni = 1'b1, a10_i = 1'b0;
  logic [1:0] ba_i = 2'd0;
  logic [2:0] bl_code_i = 3'd2;
  logic viol_o;
  logic [2:0] err_code_o;
  logic [11:0] bank_state_o;
  logic [3:0] may_act_o, may_rw_o, may_pre_o;

  sdram_cmd_tracker uut (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, tnow = 0;
  int mst[4], t_act[4], t_free[4];
  int t_last_act = -1000, t_lock = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, tnow, act, exp);
    end
  endtask

  function automatic int eff(int b);
    if ((mst[b] == 2 || mst[b] == 3) && tnow >= t_free[b]) return 0;
    return mst[b];
  endfunction

  function automatic int bl_len();
    return (bl_code_i <= 3) ? (1 << bl_code_i) : 0;
  endfunction

  task automatic check_status(input string tag);
    logic [11:0] es;
    logic [11:0] er;
    for (int b = 0; b < 4; b++) begin
      int e;
      int rs;
      e = eff(b);
      case (e)
        0: rs = 0;
        1: rs = (tnow - t_act[b] < TRCD) ? 1 : 2;
        2: rs = 3;
        default: rs = 4;
      endcase
      es[3*b +: 3] = 3'(rs);
      er[b]     = (e == 0) && (tnow - t_last_act >= TRRD) && (tnow >= t_lock);
      er[4+b]   = (e == 1) && (tnow - t_act[b] >= TRCD) && (tnow >= t_lock);
      er[8+b]   = ((e == 1) ? (tnow - t_act[b] >= TRAS) : (e != 3)) && (tnow >= t_lock);
    end
    chk(bank_state_o == es, {tag, " state"}, int'(bank_state_o), int'(es));
    chk({may_pre_o, may_rw_o, may_act_o} == er, {tag, " ready"},
        int'({may_pre_o, may_rw_o, may_act_o}), int'(er));
  endtask

  task automatic model(input int k, input int b, input bit a, output int code);
    int e;
    code = 0;
    e = eff(b);
    if (k != K_DESEL && k != K_NOP && tnow < t_lock) code = 1;
    else case (k)
      K_ACT: begin
        if (e == 2) code = 1;
        else if (e != 0) code = 2;
        else if (tnow - t_last_act < TRRD) code = 1;
        else begin mst[b] = 1; t_act[b] = tnow; t_last_act = tnow; end
      end
      K_RD, K_WR: begin
        int extra;
        extra = (k == K_WR) ? TWR - 1 : 0;
        if (e != 1) code = 2;
        else if (a && bl_len() == 0) code = 4;
        else if (tnow - t_act[b] < TRCD) code = 1;
        else if (a && (tnow + bl_len() + extra - t_act[b] < TRAS)) code = 1;
        else if (a) begin mst[b] = 3; t_free[b] = tnow + bl_len() + extra + TRP; end
      end
      K_PRE: begin
        if (a) begin
          bit ap = 0, early = 0;
          for (int i = 0; i < 4; i++) begin
            if (eff(i) == 3) ap = 1;
            if (eff(i) == 1 && tnow - t_act[i] < TRAS) early = 1;
          end
          if (ap) code = 2;
          else if (early) code = 1;
          else for (int i = 0; i < 4; i++)
            if (eff(i) == 1) begin mst[i] = 2; t_free[i] = tnow + TRP; end
        end else if (e == 3) code = 2;
        else if (e == 1) begin
          if (tnow - t_act[b] < TRAS) code = 1;
          else begin mst[b] = 2; t_free[b] = tnow + TRP; end
        end
      end
      K_TERM: if (e == 3) code = 2;
      K_REF, K_MRS: begin
        bit busy = 0;
        for (int i = 0; i < 4; i++) if (eff(i) != 0) busy = 1;
        if (busy) code = 3;
        else t_lock = tnow + ((k == K_REF) ? TRFC : TRSC);
      end
      default: ;
    endcase
  endtask

  task automatic drive(input int k, input int b, input bit a);
    logic [2:0] p;
    case (k)
      K_ACT: p = 3'b011;  K_RD: p = 3'b101;  K_WR: p = 3'b100;  K_PRE: p = 3'b010;
      K_REF: p = 3'b001;  K_MRS: p = 3'b000; K_TERM: p = 3'b110;
      K_DESEL: p = 3'($urandom_range(0, 7));
      default: p = 3'b111;
    endcase
    sel_ni = (k == K_DESEL);
    {row_ni, col_ni, wen_ni} = p;
    ba_i = 2'(b);
    a10_i = a;
  endtask

  task automatic issue(input int k, input int b, input bit a, input string tag);
    int exp;
    check_status(tag);
    model(k, b, a, exp);
    drive(k, b, a);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(viol_o == (exp != 0) && err_code_o == 3'(exp), tag, int'({viol_o, err_code_o}),
        int'({exp != 0, 3'(exp)}));
    tnow++;
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin mst[b] = 0; t_act[b] = -1000; t_free[b] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(viol_o == 1'b0 && err_code_o == 3'd0, "R13 reset", int'(viol_o), 0);
    check_status("R13 reset");
    issue(K_DESEL, 1, 1, "R1");
    issue(K_NOP, 2, 1, "R1");
    issue(K_ACT, 0, 0, "R2");
    issue(K_RD, 0, 0, "R2");
    issue(K_RD, 0, 0, "R2");
    issue(K_ACT, 1, 0, "R3");
    issue(K_ACT, 2, 0, "R3");
    issue(K_ACT, 2, 0, "R3");
    issue(K_RD, 3, 0, "R14");
    issue(K_ACT, 1, 0, "R14");
    issue(K_PRE, 2, 0, "R4");
    nops(5, "R4");
    issue(K_PRE, 2, 0, "R4");
    issue(K_ACT, 2, 0, "R4");
    issue(K_NOP, 0, 0, "R4");
    issue(K_ACT, 2, 0, "R4");
    issue(K_PRE, 3, 0, "R4");
    issue(K_REF, 0, 0, "R8");
    issue(K_MRS, 0, 0, "R8");
    nops(5, "R5");
    issue(K_PRE, 3, 1, "R5");
    nops(2, "R5");
    issue(K_REF, 0, 0, "R9");
    issue(K_ACT, 0, 0, "R9");
    nops(6, "R9");
    issue(K_ACT, 0, 0, "R9");
    nops(5, "R9");
    issue(K_PRE, 0, 0, "R9");
    nops(2, "R9");
    issue(K_MRS, 0, 0, "R9");
    issue(K_ACT, 1, 0, "R9");
    issue(K_NOP, 0, 0, "R9");
    issue(K_ACT, 1, 0, "R9");
    issue(K_NOP, 0, 0, "R10");
    issue(K_ACT, 2, 0, "R10");
    bl_code_i = 3'd0;
    issue(K_NOP, 0, 0, "R10");
    issue(K_RD, 2, 1, "R10");
    bl_code_i = 3'd3;
    issue(K_RD, 2, 1, "R6");
    issue(K_TERM, 2, 0, "R7");
    issue(K_RD, 1, 0, "R7");
    issue(K_PRE, 2, 0, "R7");
    nops(5, "R6");
    issue(K_ACT, 2, 0, "R6");
    issue(K_ACT, 2, 0, "R6");
    bl_code_i = 3'd2;
    nops(4, "R6");
    issue(K_WR, 2, 1, "R6");
    nops(5, "R6");
    issue(K_ACT, 2, 0, "R6");
    issue(K_ACT, 2, 0, "R6");
    bl_code_i = 3'd7;
    nops(3, "R11");
    issue(K_RD, 2, 1, "R11");
    issue(K_WR, 2, 1, "R11");
    issue(K_RD, 2, 0, "R11");
    issue(K_TERM, 2, 0, "R14");
    for (int i = 0; i < 3000; i++) begin
      int r, k;
      if (i % 40 == 0) begin
        r = $urandom_range(0, 4);
        bl_code_i = (r == 4) ? 3'd7 : 3'(r);
      end
      r = $urandom_range(0, 99);
      if (r < 45) k = K_NOP;
      else if (r < 50) k = K_DESEL;
      else if (r < 64) k = K_ACT;
      else if (r < 72) k = K_RD;
      else if (r < 80) k = K_WR;
      else if (r < 90) k = K_PRE;
      else if (r < 94) k = K_TERM;
      else if (r < 97) k = K_REF;
      else k = K_MRS;
      issue(k, $urandom_range(0, 3), ($urandom_range(0, 3) == 0), "R12");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule